// File: doc/BRIEF.md
# Dual Four-Mode Counter/Timer

This block contains two independent 16-bit counters. Software reaches each one as a low byte and a high byte. Each counter is set to one of four modes: a 13-bit count, a plain 16-bit count, an 8-bit count that reloads itself from the high byte, or a split mode. In split mode, timer 0 runs as two separate 8-bit counters. Each timer counts one of two things: ticks of a selected time base, or falling edges on its own event pin. The event pin is sampled by the system clock.

Each timer has a sticky overflow flag, and a per-timer enable turns that flag into an interrupt request. The time base of each timer is either the system clock or a shared prescaled tick. A 2-bit scale field picks the prescaled tick: the system clock divided by one of three ratios, or an external oscillator divided by eight. All dividing is done with clock-enable pulses, so the whole block runs in one clock domain. Bus decode and pin routing belong to the surrounding logic. Configuration arrives here as plain inputs, and the byte registers are reached through a small select/data port.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset, both counts read 0x0000, both flags are 0 and both interrupt requests are 0.
- R2: Byte select codes for `wr_sel` and `rd_sel` are: 0 for the timer 0 low byte, 1 for the timer 0 high byte, 2 for the timer 1 low byte and 3 for the timer 1 high byte. A write replaces that byte at the next edge. In that same cycle, the write suppresses counting of whichever counter owns the byte. Outside split mode a timer owns both of its bytes. In split mode, timer 0's low byte and high byte have separate owners.
- R3: Mode code 00 is the 13-bit mode. The count value is the high byte joined with low byte bits 4..0. A wrap from 0x1FFF to 0x0000 sets the flag. Low byte bits 7..5 keep their value.
- R4: Mode code 01 is the 16-bit mode. A wrap from 0xFFFF to 0x0000 sets the flag.
- R5: Mode code 10 is the 8-bit reload mode. The low byte counts. When it steps past 0xFF, it is loaded from the high byte and the flag sets. The high byte does not change.
- R6: Mode code 11 on timer 0 is the split mode. The low byte counts under timer 0's run bit and source, and sets flag 0. The high byte counts timer 0's time base, never events, under timer 1's run bit, and its wrap past 0xFF sets flag 1.
- R7: Mode code 11 on timer 1 holds timer 1's count unchanged.
- R8: When `cnt_sel[t]`=1, the count advances once per falling edge on `evt_pin[t]`. Rising edges do not advance it. A level held for at least two cycles is always seen, so a pin that toggles every two cycles is counted in full.
- R9: When `cnt_sel[t]`=0, the count advances on the time base. `clk_sel[t]`=1 selects every system clock, and `clk_sel[t]`=0 selects the prescaled tick.
- R10: The shared `scale` field gives the prescaled tick rate. Code 00 is the system clock divided by 12, 01 is divided by 4, 10 is divided by 48, and 11 is rising edges of `ext_osc` divided by 8.
- R11: When `run[t]`=0, that timer's counter does not advance, whatever clock or event input it sees.
- R12: A flag stays set until a `flag_clr` pulse clears it. An overflow in the same cycle as a clear leaves the flag set. `irq[t]` equals `flag[t]` AND `int_en[t]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 2 | Byte select for the write |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Byte select for the read |
| rd_data | output | 8 | Selected byte (combinational) |
| mode0 | input | 2 | Timer 0 mode code |
| mode1 | input | 2 | Timer 1 mode code |
| cnt_sel | input | 2 | Per timer: 1 counts events, 0 counts the time base |
| clk_sel | input | 2 | Per timer: 1 selects the system clock, 0 the prescaled tick |
| scale | input | 2 | Shared prescaler select |
| run | input | 2 | Per timer run enable |
| int_en | input | 2 | Per timer interrupt enable |
| flag_clr | input | 2 | Per timer flag clear pulse |
| evt_pin | input | 2 | Per timer external event pin |
| ext_osc | input | 1 | External oscillator input for prescaler code 11 |
| flag | output | 2 | Sticky overflow flags |
| irq | output | 2 | Interrupt requests |

## Verification
The hardest case to reach is a counter event that lands in the same cycle as something else: a byte write, a flag clear, or a second counter in split mode sharing the other timer's flag. Directed sequences preload counts a few steps short of a wrap, so these collisions fall on chosen edges. One case writes the low byte on the edge that would carry into the high byte. Another clears the flag on the exact wrap edge. A third sets both split halves one step apart from their wraps. Random runs of the 13-bit and 16-bit modes cover arbitrary start values and lengths. Prescaler windows are whole multiples of each ratio, so the expected count does not depend on the divider phase.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

  typedef enum logic [1:0] {
    M_13     = 2'b00,
    M_16     = 2'b01,
    M_RELOAD = 2'b10,
    M_SPLIT  = 2'b11
  } tmode_e;

  // One step of the main counter: returns {overflow, next count}.
  function automatic logic [16:0] f_next(input tmode_e m, input logic [15:0] c);
    logic [13:0] s13;
    logic [16:0] r;
    unique case (m)
      M_13: begin
        s13 = {1'b0, c[15:8], c[4:0]} + 14'd1;
        r   = {s13[13], s13[12:5], c[7:5], s13[4:0]};
      end
      M_16:     r = {1'b0, c} + 17'd1;
      M_RELOAD: r = (c[7:0] == 8'hFF) ? {1'b1, c[15:8], c[15:8]}
                                      : {1'b0, c[15:8], c[7:0] + 8'd1};
      default:  r = {c[7:0] == 8'hFF, c[15:8], c[7:0] + 8'd1};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dmt_sync_edge.sv
module dmt_sync_edge #(
  parameter bit RISE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic pulse
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  generate
    if (RISE) begin : g_rise
      assign pulse = s2 & ~s3;
    end else begin : g_fall
      assign pulse = ~s2 & s3;
    end
  endgenerate
endmodule

// File: rtl/dmt_prescale.sv
module dmt_prescale #(
  parameter int DIV_A   = 12,
  parameter int DIV_B   = 4,
  parameter int DIV_C   = 48,
  parameter int EXT_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] scale,
  input  logic       ext_osc,
  output logic       pre_tick
);
  function automatic int f_max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  localparam int CW = $clog2(f_max3(DIV_A, DIV_B, DIV_C) + 1);
  localparam int EW = $clog2(EXT_DIV + 1);

  logic [2:0] hit;

  for (genvar g = 0; g < 3; g++) begin : g_div
    localparam int D = (g == 0) ? DIV_A : (g == 1) ? DIV_B : DIV_C;
    logic [CW-1:0] c;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 c <= '0;
      else if (c == CW'(D - 1))   c <= '0;
      else                        c <= c + CW'(1);
    end
    assign hit[g] = (c == CW'(D - 1));
  end

  logic          ext_rise;
  logic [EW-1:0] ec;

  dmt_sync_edge #(.RISE(1'b1)) u_ext (
    .clk(clk), .rst_n(rst_n), .pin(ext_osc), .pulse(ext_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   ec <= '0;
    else if (ext_rise && ec == EW'(EXT_DIV - 1))  ec <= '0;
    else if (ext_rise)                            ec <= ec + EW'(1);
  end

  always_comb begin
    unique case (scale)
      2'b00:   pre_tick = hit[0];
      2'b01:   pre_tick = hit[1];
      2'b10:   pre_tick = hit[2];
      default: pre_tick = ext_rise && (ec == EW'(EXT_DIV - 1));
    endcase
  end
endmodule

// File: rtl/dmt_timer_core.sv
module dmt_timer_core
  import dmt_pkg::*;
#(
  parameter bit SPLIT_CAP = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  tmode_e      mode,
  input  logic        tick_main,
  input  logic        tick_hi,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [7:0]  wdata,
  output logic [15:0] cnt,
  output logic        ovf_main,
  output logic        ovf_hi
);
  logic        split, go_main, go_hi;
  logic [15:0] nxt;
  logic [16:0] stepv;

  assign split   = (mode == M_SPLIT);
  assign go_main = tick_main && !wr_lo && !(wr_hi && !split) && (SPLIT_CAP || !split);
  assign go_hi   = SPLIT_CAP && split && tick_hi && !wr_hi;
  assign stepv   = f_next(mode, cnt);

  always_comb begin
    nxt      = cnt;
    ovf_main = 1'b0;
    ovf_hi   = 1'b0;
    if (go_main) begin
      nxt      = stepv[15:0];
      ovf_main = stepv[16];
    end
    if (go_hi) begin
      nxt[15:8] = cnt[15:8] + 8'd1;
      ovf_hi    = &cnt[15:8];
    end
    if (wr_lo) nxt[7:0]  = wdata;
    if (wr_hi) nxt[15:8] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt;
  end
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
  import dmt_pkg::*;
#(
  parameter int DIV_A   = 12,
  parameter int DIV_B   = 4,
  parameter int DIV_C   = 48,
  parameter int EXT_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_sel,
  output logic [7:0] rd_data,
  input  logic [1:0] mode0,
  input  logic [1:0] mode1,
  input  logic [1:0] cnt_sel,
  input  logic [1:0] clk_sel,
  input  logic [1:0] scale,
  input  logic [1:0] run,
  input  logic [1:0] int_en,
  input  logic [1:0] flag_clr,
  input  logic [1:0] evt_pin,
  input  logic       ext_osc,
  output logic [1:0] flag,
  output logic [1:0] irq
);
  localparam int NT = 2;

  // Named internal events (observed by the checker).
  logic        pre_tick;
  logic [1:0]  evt_fall;
  logic [1:0]  tclk;
  logic [1:0]  tick_main;
  logic [1:0]  ovf_main;
  logic [1:0]  ovf_hi;
  logic        tick_hi0;
  logic [15:0] cnt_v [NT];
  logic [15:0] cnt0, cnt1;
  tmode_e      mode_v [NT];
  logic [1:0]  flag_q, flag_set;

  assign mode_v[0] = tmode_e'(mode0);
  assign mode_v[1] = tmode_e'(mode1);

  dmt_prescale #(
    .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C), .EXT_DIV(EXT_DIV)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .scale(scale), .ext_osc(ext_osc), .pre_tick(pre_tick)
  );

  assign tick_hi0 = run[1] & tclk[0];

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    logic wr_lo_t, wr_hi_t;

    dmt_sync_edge #(.RISE(1'b0)) u_evt (
      .clk(clk), .rst_n(rst_n), .pin(evt_pin[t]), .pulse(evt_fall[t])
    );

    assign tclk[t]      = clk_sel[t] | pre_tick;
    assign tick_main[t] = run[t] & (cnt_sel[t] ? evt_fall[t] : tclk[t]);
    assign wr_lo_t      = wr_en && (wr_sel == 2'(2 * t));
    assign wr_hi_t      = wr_en && (wr_sel == 2'(2 * t + 1));

    dmt_timer_core #(.SPLIT_CAP(t == 0)) u_core (
      .clk(clk), .rst_n(rst_n), .mode(mode_v[t]),
      .tick_main(tick_main[t]), .tick_hi((t == 0) ? tick_hi0 : 1'b0),
      .wr_lo(wr_lo_t), .wr_hi(wr_hi_t), .wdata(wr_data),
      .cnt(cnt_v[t]), .ovf_main(ovf_main[t]), .ovf_hi(ovf_hi[t])
    );
  end

  assign cnt0 = cnt_v[0];
  assign cnt1 = cnt_v[1];

  // Split high half of timer 0 reports through timer 1's flag.
  assign flag_set = {ovf_main[1] | ovf_hi[0] | ovf_hi[1], ovf_main[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_set | (flag_q & ~flag_clr);
  end

  assign flag = flag_q;
  assign irq  = flag_q & int_en;

  always_comb begin
    unique case (rd_sel)
      2'd0:    rd_data = cnt0[7:0];
      2'd1:    rd_data = cnt0[15:8];
      2'd2:    rd_data = cnt1[7:0];
      default: rd_data = cnt1[15:8];
    endcase
  end
endmodule

module dmt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [1:0]  mode0,
  input logic [1:0]  mode1,
  input logic [1:0]  cnt_sel,
  input logic [1:0]  run,
  input logic [1:0]  flag_clr,
  input logic [1:0]  flag,
  input logic [1:0]  evt_fall,
  input logic [1:0]  ovf_main,
  input logic [15:0] cnt0,
  input logic [15:0] cnt1
);
  a_r11_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (run == 2'b00 && !wr_en) |=> ($stable(cnt0) && $stable(cnt1)));

  a_r7_split_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode1 == 2'b11 && !wr_en) |=> $stable(cnt1));

  a_r3_upper_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (mode0 == 2'b00 && !(wr_en && wr_sel == 2'b00)) |=> $stable(cnt0[7:5]));

  a_r8_event_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_fall[0] && cnt_sel[0] && run[0] && mode0 == 2'b01 && !wr_en)
      |=> (cnt0 == $past(cnt0) + 16'd1));

  a_r12_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_main[0] |=> flag[0]);

  a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[1] && !flag_clr[1]) |=> flag[1]);
endmodule

bind dual_mode_timer dmt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .mode0(mode0), .mode1(mode1), .cnt_sel(cnt_sel), .run(run),
  .flag_clr(flag_clr), .flag(flag), .evt_fall(evt_fall),
  .ovf_main(ovf_main), .cnt0(cnt0), .cnt1(cnt1)
);

// File: tb/sim_dual_mode_timer.sv
`timescale 1ns/100ps
module sim_dual_mode_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic [1:0] mode0 = 2'b01, mode1 = 2'b01;
  logic [1:0] cnt_sel = '0, clk_sel = 2'b11, scale = '0;
  logic [1:0] run = '0, int_en = '0, flag_clr = '0, evt_pin = '0;
  logic       ext_osc = 1'b0;
  logic [1:0] flag, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dual_mode_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .mode0(mode0), .mode1(mode1),
    .cnt_sel(cnt_sel), .clk_sel(clk_sel), .scale(scale), .run(run),
    .int_en(int_en), .flag_clr(flag_clr), .evt_pin(evt_pin), .ext_osc(ext_osc),
    .flag(flag), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic load(input int t, input logic [15:0] v);
    wr(2'(2 * t), v[7:0]);
    wr(2'(2 * t + 1), v[15:8]);
  endtask

  task automatic rd16(input int t, output logic [15:0] v);
    rd_sel = 2'(2 * t + 1); #0.2; v[15:8] = rd_data;
    rd_sel = 2'(2 * t);     #0.2; v[7:0]  = rd_data;
  endtask

  task automatic clr_flags();
    flag_clr = 2'b11; cyc(1); flag_clr = 2'b00;
  endtask

  task automatic run_for(input int t, input int n);
    run[t] = 1'b1; cyc(n); run[t] = 1'b0;
  endtask

  // Bench model: advance by n ticks, report whether a wrap occurred.
  function automatic logic [16:0] model(input logic [1:0] m, input logic [15:0] s, input int n);
    int v;
    if (m == 2'b00) begin
      v = (int'(s[15:8]) * 32 + int'(s[4:0])) + n;
      return {v >= 8192, 8'(v / 32 % 256), s[7:5], 5'(v % 32)};
    end
    v = int'(s) + n;
    return {v >= 65536, 16'(v % 65536)};
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    logic [16:0] e;
    int unsigned sd;
    sd = $urandom(32'd2024);
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    rd16(0, v); chk("R1 cnt0", v, 16'h0000);
    rd16(1, v); chk("R1 cnt1", v, 16'h0000);
    chk("R1 flag", flag, 2'b00);
    chk("R1 irq", irq, 2'b00);

    // R3 13-bit wrap, upper low bits kept, irq gated
    mode0 = 2'b00; load(0, 16'hFFBE);
    run_for(0, 2);
    rd16(0, v); chk("R3 13-bit wrap value", v, 16'h00A0);
    chk("R3 flag set", flag[0], 1'b1);
    chk("R12 irq masked", irq[0], 1'b0);
    int_en = 2'b01; #0.2;
    chk("R12 irq enabled", irq[0], 1'b1);
    int_en = 2'b00; clr_flags();
    chk("R12 flag cleared", flag, 2'b00);

    // R4 16-bit wrap; R12 set wins over clear in same cycle
    mode0 = 2'b01; load(0, 16'hFFFE);
    run_for(0, 1);
    chk("R4 no early flag", flag[0], 1'b0);
    run[0] = 1'b1; flag_clr = 2'b01; cyc(1); run[0] = 1'b0; flag_clr = 2'b00;
    rd16(0, v); chk("R4 16-bit wrap", v, 16'h0000);
    chk("R12 set wins over clear", flag[0], 1'b1);
    cyc(2);
    chk("R12 flag sticky", flag[0], 1'b1);
    clr_flags();

    // R2 write suppresses the carry that would have happened
    load(0, 16'h01FF);
    run[0] = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h50;
    cyc(1); wr_en = 1'b0;
    rd16(0, v); chk("R2 write suppresses count", v, 16'h0150);
    cyc(1); run[0] = 1'b0;
    rd16(0, v); chk("R2 count resumes", v, 16'h0151);

    // R5 reload
    mode0 = 2'b10; load(0, 16'hF0FE);
    run_for(0, 2);
    rd16(0, v); chk("R5 reload value", v, 16'hF0F0);
    chk("R5 flag", flag[0], 1'b1);
    clr_flags();
    run_for(0, 16);
    rd16(0, v); chk("R5 second reload", v, 16'hF0F0);
    chk("R5 flag again", flag[0], 1'b1);
    clr_flags();

    // R6 split timer 0, R7 timer 1 held
    mode0 = 2'b11; mode1 = 2'b11;
    load(0, 16'hFDFE); load(1, 16'h1234);
    int_en = 2'b01;
    run = 2'b11; cyc(3); run = 2'b00;
    rd16(0, v); chk("R6 split halves", v, 16'h0001);
    chk("R6 both flags", flag, 2'b11);
    chk("R12 irq per enable", irq, 2'b01);
    rd16(1, v); chk("R7 timer1 held", v, 16'h1234);
    int_en = 2'b00; clr_flags();
    // R6 split high half ignores events
    cnt_sel = 2'b01; load(0, 16'h1000);
    run = 2'b11; cyc(4); run = 2'b00; cnt_sel = 2'b00;
    rd16(0, v); chk("R6 high half counts clock, low waits for events", v, 16'h1400);
    mode0 = 2'b01; mode1 = 2'b01;

    // R8 events: toggling every two cycles, all falls counted
    cnt_sel = 2'b01; load(0, 16'h0000); run[0] = 1'b1;
    for (int k = 0; k < 10; k++) begin
      evt_pin[0] = 1'b1; cyc(2); evt_pin[0] = 1'b0; cyc(2);
    end
    cyc(4); run[0] = 1'b0;
    rd16(0, v); chk("R8 event count", v, 16'd10);
    // R8 rising edge alone does not count
    run[0] = 1'b1; evt_pin[0] = 1'b1; cyc(6); run[0] = 1'b0;
    rd16(0, v); chk("R8 rising ignored", v, 16'd10);
    // R11 events ignored while stopped
    for (int k = 0; k < 5; k++) begin
      evt_pin[0] = 1'b0; cyc(2); evt_pin[0] = 1'b1; cyc(2);
    end
    evt_pin[0] = 1'b0; cyc(5);
    rd16(0, v); chk("R11 stopped ignores events", v, 16'd10);
    cnt_sel = 2'b00;

    // R9/R10 prescaled time base on timer 1
    clk_sel = 2'b01;
    scale = 2'b00; load(1, 16'h0000); run_for(1, 480);
    rd16(1, v); chk("R10 div12", v, 16'd40);
    scale = 2'b01; load(1, 16'h0000); run_for(1, 480);
    rd16(1, v); chk("R10 div4", v, 16'd120);
    scale = 2'b10; load(1, 16'h0000); run_for(1, 480);
    rd16(1, v); chk("R10 div48", v, 16'd10);
    scale = 2'b11; load(1, 16'h0000); run[1] = 1'b1;
    for (int k = 0; k < 64; k++) begin
      ext_osc = 1'b1; cyc(2); ext_osc = 1'b0; cyc(2);
    end
    cyc(6); run[1] = 1'b0;
    rd16(1, v); chk("R10 ext div8", v, 16'd8);
    scale = 2'b01; clk_sel = 2'b11;
    load(1, 16'h0000); run_for(1, 37);
    rd16(1, v); chk("R9 system clock select", v, 16'd37);
    clr_flags();

    // Random runs of 13-bit and 16-bit modes (R3, R4, R11)
    for (int it = 0; it < 24; it++) begin
      int t, n;
      logic [1:0] m;
      logic [15:0] s;
      t = int'($urandom % 2);
      m = ($urandom % 2) ? 2'b01 : 2'b00;
      s = 16'($urandom);
      if (it < 6) s = (m == 2'b00) ? {8'hFF, s[7:5], 5'h10} : 16'hFFF0;
      n = 1 + int'($urandom % 300);
      if (t == 0) mode0 = m; else mode1 = m;
      load(t, s);
      clr_flags();
      run_for(t, n);
      cyc(int'($urandom % 3));
      e = model(m, s, n);
      rd16(t, v);
      chk((m == 2'b00) ? "R3 random count" : "R4 random count", v, e[15:0]);
      chk("R12 random flag", flag[t], e[16]);
    end

    finish_run();
  end
endmodule